// File: doc/BRIEF.md
# Per-port input change interrupt

This block raises the interrupt line of a 16-bit general purpose I/O expander. A pin that is set up as an input is compared, level against level, with the value last captured for it in its port's input snapshot register. When any such pin disagrees with its snapshot, the shared interrupt line is pulled low. Because the comparison is a level comparison and not an edge detector, the request goes away again if the pin returns to the captured value.

The pins are grouped into 8-bit ports. Each port keeps its own pending flag. The snapshot storage lives outside the block; it drives the snapshot contents and a read strobe for each port into this block. On the clock edge where a port's strobe is high, the outside storage captures that port's current pin levels, and on the same edge this block drops that port's request. The other port is left alone. The line is produced as an active-low level plus a separate pull-down enable, so that a pad can build an open-drain output from them.

Top module: `gpio_change_irq`

## Requirements
- R1: When an input-configured pin (direction bit 1) differs from its snapshot bit and its port is not being read, `irq_n` is low after the next rising clock edge.
- R2: When every input-configured pin again matches its snapshot and no read is involved, `irq_n` returns high after the next rising clock edge.
- R3: A read strobe on a port (`snap_rd[p]` high, where bit p covers pins p*8 to p*8+7) removes that port's request on that edge, including when a pin of the port changes in the same cycle. The snapshot is recaptured on that edge, so the request stays removed until a pin of the port changes again.
- R4: A read strobe on one port never clears a request held by the other port, also when the other port's pin changes in the very cycle of the read.
- R5: A pin whose direction bit is 0 (output) never causes a request, whatever its level.
- R6: Changing a direction bit from 0 to 1 while that pin differs from its snapshot raises the interrupt after the next edge.
- R7: `irq_drv` is high in exactly the cycles in which `irq_n` is low.
- R8: While reset is held, `irq_n` is high and `irq_drv` is low.
- R9: `irq_n` is a registered output: a change of its inputs shows on it one clock later, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 16 | Synchronized pin levels, port p on bits p*8+7..p*8 |
| in_snap | input | 16 | Current contents of the input snapshot registers |
| dir_in | input | 16 | Direction per pin, 1 = input, 0 = output |
| snap_rd | input | 2 | Per-port read strobe; snapshot recaptured on this edge |
| irq_n | output | 1 | Active-low interrupt level |
| irq_drv | output | 1 | Pull-down enable for an open-drain pad |

## Verification
The case that needs care is a read that clears one port while a pin of the other port changes in the same cycle. The bench drives the port 0 strobe together with a port 1 pin flip in one step. The expected line is low, because the port 1 request must survive the port 0 clear. The bench also covers a read that lands together with a pin change on the same port. There the recaptured snapshot takes in the new level, so the expected line is high, and the bench's own snapshot model follows the same edge to judge the next cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Direction encoding shared by the whole expander
  localparam logic DIR_OUT = 1'b0;
  localparam logic DIR_IN  = 1'b1;

  // Lowest pin index of a port
  function automatic int port_base(input int port, input int width);
    return port * width;
  endfunction

endpackage

// File: rtl/gpio_port_watch.sv
module gpio_port_watch #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin,
  input  logic [PORT_W-1:0] snap,
  input  logic [PORT_W-1:0] dir,
  input  logic              rd,
  output logic              pend_next,
  output logic              pend_q
);
  import gpio_irq_pkg::*;

  // Bits that may raise a request: input direction and level mismatch
  function automatic logic [PORT_W-1:0] live_diff(
    input logic [PORT_W-1:0] p,
    input logic [PORT_W-1:0] s,
    input logic [PORT_W-1:0] d
  );
    logic [PORT_W-1:0] r;
    for (int i = 0; i < PORT_W; i++)
      r[i] = (d[i] == DIR_IN) && (p[i] != s[i]);
    return r;
  endfunction

  logic [PORT_W-1:0] diff_bits;
  logic              any_diff;

  assign diff_bits = live_diff(pin, snap, dir);
  assign any_diff  = |diff_bits;
  // A read recaptures the snapshot on this edge, so the port stays quiet
  assign pend_next = any_diff && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next;
  end

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !pend_q);

  // R5
  outputs_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == '0) |=> !pend_q);

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] pend_next,
  output logic             irq_n,
  output logic             irq_drv
);
  logic any_pend;
  assign any_pend = |pend_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n   <= 1'b1;
      irq_drv <= 1'b0;
    end else begin
      irq_n   <= !any_pend;
      irq_drv <= any_pend;
    end
  end

  // R1
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_next) |=> !irq_n);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_next) |=> irq_n);

  // R7
  drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drv != irq_n);

endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq #(
  parameter int PORTS  = 2,
  parameter int PORT_W = 8,
  localparam int PIN_W = PORTS * PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_lvl,
  input  logic [PIN_W-1:0] in_snap,
  input  logic [PIN_W-1:0] dir_in,
  input  logic [PORTS-1:0] snap_rd,
  output logic             irq_n,
  output logic             irq_drv
);
  import gpio_irq_pkg::*;

  logic [PORTS-1:0] port_pend_next;
  logic [PORTS-1:0] port_pend_q;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int LO = port_base(p, PORT_W);
    gpio_port_watch #(.PORT_W(PORT_W)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (pin_lvl[LO +: PORT_W]),
      .snap      (in_snap[LO +: PORT_W]),
      .dir       (dir_in[LO +: PORT_W]),
      .rd        (snap_rd[p]),
      .pend_next (port_pend_next[p]),
      .pend_q    (port_pend_q[p])
    );
  end

  gpio_irq_merge #(.PORTS(PORTS)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_next (port_pend_next),
    .irq_n     (irq_n),
    .irq_drv   (irq_drv)
  );

  if (PORTS >= 2) begin : g_iso
    // R4
    port_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_rd[0] && port_pend_next[1]) |=> (!irq_n && port_pend_q[1]));
  end

endmodule

// File: tb/sim_gpio_change_irq.sv
`timescale 1ns/100ps
module sim_gpio_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = 16'h5A3C;
  logic [15:0] cfg = 16'hFFFF;
  logic [1:0]  rd = 2'b00;
  logic [15:0] lat;
  logic        irq_n, irq_drv;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  typedef struct { logic exp_n; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  gpio_change_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin), .in_snap(lat),
    .dir_in(cfg), .snap_rd(rd), .irq_n(irq_n), .irq_drv(irq_drv)
  );

  // Bench model of the snapshot registers outside the block
  always_ff @(posedge clk) begin
    if (!rst_n) lat <= pin;
    else begin
      if (rd[0]) lat[7:0]  <= pin[7:0];
      if (rd[1]) lat[15:8] <= pin[15:8];
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected line level
  task automatic step(input logic [15:0] p, input logic [15:0] c,
                      input logic [1:0] r, input string tag);
    item_t it;
    logic req;
    @(negedge clk);
    pin = p; cfg = c; rd = r;
    req = 1'b0;
    for (int port = 0; port < 2; port++) begin
      logic hit = 1'b0;
      for (int b = 0; b < 8; b++)
        if (c[port*8+b] && (p[port*8+b] != lat[port*8+b])) hit = 1'b1;
      if (hit && !r[port]) req = 1'b1;
    end
    it.exp_n = !req;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare just after the edge that registers the result
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(irq_n, it.exp_n, it.tag);
      check(irq_drv, !it.exp_n, {it.tag, " R7 drv"});
    end
  end

  initial begin
    logic [15:0] a, b, c, d;
    repeat (4) @(negedge clk);
    check(irq_n, 1'b1, "R8 reset irq_n");
    check(irq_drv, 1'b0, "R8 reset irq_drv");
    rst_n = 1'b1;
    a = 16'h5A3C;
    step(a, 16'hFFFF, 2'b00, "R8 idle after reset");
    step(a ^ 16'h0008, 16'hFFFF, 2'b00, "R1 port0 change");
    step(a, 16'hFFFF, 2'b00, "R2 revert");
    step(a ^ 16'h0008, 16'hFFFF, 2'b00, "R1 change again");
    step(a ^ 16'h0008, 16'hFFFF, 2'b01, "R3 read port0");
    b = a ^ 16'h0008;
    step(b, 16'hFFFF, 2'b00, "R3 relatched");
    c = b ^ 16'h0101;
    step(c, 16'hFFFF, 2'b00, "R1 both ports");
    step(c, 16'hFFFF, 2'b01, "R4 port1 kept on port0 read");
    step(c, 16'hFFFF, 2'b00, "R4 port1 still pending");
    step(c, 16'hFFFF, 2'b10, "R4 port1 read");
    step(c ^ 16'h0200, 16'hFFFF, 2'b01, "R4 same cycle port1 change");
    step(c, 16'hFFFF, 2'b00, "R2 port1 revert");
    step(c ^ 16'h0010, 16'hFFEF, 2'b00, "R5 output pin change");
    step(c ^ 16'h0010, 16'hFFEF, 2'b00, "R5 output pin held");
    step(c ^ 16'h0010, 16'hFFFF, 2'b00, "R6 output to input");
    step(c ^ 16'h0010, 16'hFFFF, 2'b01, "R3 read clears R6");
    d = c ^ 16'h0010;
    step(d ^ 16'h0040, 16'hFFFF, 2'b01, "R3 change on read edge");
    step(d ^ 16'h0040, 16'hFFFF, 2'b00, "R3 new level captured");
    step(~(d ^ 16'h0040), 16'h0000, 2'b00, "R5 all outputs");
    // R9: a change applied now must not reach irq_n before the edge
    @(negedge clk);
    pin = d ^ 16'h0040 ^ 16'h8000; cfg = 16'hFFFF; rd = 2'b00;
    #1 check(irq_n, 1'b1, "R9 no same-cycle change");
    @(posedge clk); #1 check(irq_n, 1'b0, "R9 one cycle later");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule